// File: doc/BRIEF.md
# Fixed-Region Address Protection and Translation Unit

This unit checks and translates addresses for a core whose address space is cut into eight equal segments of 512 MB each. The top three address bits choose the segment. Each segment has an entry in a small table. The entry holds the segment's physical base (only the three upper bits, because a base is always aligned to the segment size) and a 4-bit protection code. The code decodes into read, write and execute rights and a caching policy.

A request carries a virtual address and an access kind: load, store or fetch. One clock later the unit returns either the physical address and the caching policy, or a fault with a cause code that depends on the access kind. In the alternate cache-attribute mode the table is bypassed. The protection code then comes from the matching nibble of a 32-bit cache-attribute word, and the address passes through untranslated. The table is loaded through a one-entry-per-cycle write port, and reset fills it with an identity map that grants every kind of access.

Top module: `rgn_guard_top`

## Requirements
- R1: After reset, every segment maps to itself with protection code 2, so every access kind is granted, rsp_paddr equals the request address and the cache policy is bypass.
- R2: The segment index is req_addr[31:29]; the other address bits never select an entry.
- R3: In table mode a granted response has rsp_paddr = {segment base (3 bits), req_addr[28:0]}.
- R4: Protection codes decode as follows. 0 is read/write. 1, 2, 4 and 5 are read/write/execute. 3 is execute-only. 14 is read/write. Every other code grants nothing. A load needs read, a store needs write and a fetch needs execute.
- R5: rsp_cache encodes the policy as 0 bypass, 1 write-through, 2 write-back and 3 isolate. Codes 0 and 1 give write-through, 2 gives bypass, 3, 4 and 5 give write-back, and 14 gives isolate.
- R6: A denied access sets rsp_fault and rsp_cause (1 load, 2 store, 3 fetch) and drives rsp_paddr and rsp_cache to 0. A granted access gives rsp_fault=0 and rsp_cause=0.
- R7: When cattr_mode=1, the protection code is cattr_word[4*i+3:4*i] for segment i, and rsp_paddr equals req_addr; the table contents have no effect.
- R8: When cattr_mode=1, protection code 5 grants no access.
- R9: A request sampled at a rising edge is answered at that same edge's outputs (one cycle of latency). With req_valid low, rsp_valid and all other outputs are 0 on the following cycle.
- R10: A table write (wr_en, wr_idx, wr_base, wr_attr) becomes visible to requests from the next cycle on. A request in the same cycle as the write still sees the old entry.
- R11: Access kind encoding: 0 load, 1 store, 2 fetch; the value 3 is treated as a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 3 | Segment entry to write |
| wr_base | input | 3 | New physical base (upper address bits) |
| wr_attr | input | 4 | New protection code |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind |
| cattr_mode | input | 1 | Take the protection code from cattr_word |
| cattr_word | input | 32 | Eight 4-bit protection codes, one per segment |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_cache | output | 2 | Cache policy (0 on fault) |
| rsp_fault | output | 1 | Access denied |
| rsp_cause | output | 2 | Fault cause, 0 when granted |

## Verification
The assertions assume that reset is held for at least one clock before any request is judged, and that every input is stable and defined around each rising edge. The bench meets both conditions: it asserts reset for several cycles at the start and changes inputs only on falling edges. The cache-attribute check also assumes cattr_word stays steady across the edge where a request is sampled, and the bench changes that word only together with a new request. Requests and table writes are allowed in the same cycle, which exercises the old-versus-new entry ordering.

// File: rtl/rgn_pkg.sv
package rgn_pkg;
  localparam int unsigned ATTR_W = 4;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;

  localparam logic [1:0] CM_BYPASS = 2'd0;
  localparam logic [1:0] CM_WTHRU  = 2'd1;
  localparam logic [1:0] CM_WBACK  = 2'd2;
  localparam logic [1:0] CM_ISOL   = 2'd3;

  localparam logic [1:0] CS_NONE  = 2'd0;
  localparam logic [1:0] CS_LOAD  = 2'd1;
  localparam logic [1:0] CS_STORE = 2'd2;
  localparam logic [1:0] CS_FETCH = 2'd3;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       ex;
    logic [1:0] cm;
  } rights_t;
endpackage

// File: rtl/rgn_table.sv
module rgn_table #(
  parameter int unsigned RGN_BITS = 3,
  parameter int unsigned ATTR_W   = 4,
  parameter logic [ATTR_W-1:0] RST_ATTR = 4'd2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [RGN_BITS-1:0] wr_idx,
  input  logic [RGN_BITS-1:0] wr_base,
  input  logic [ATTR_W-1:0]   wr_attr,
  input  logic [RGN_BITS-1:0] rd_idx,
  output logic [RGN_BITS-1:0] rd_base,
  output logic [ATTR_W-1:0]   rd_attr
);
  localparam int unsigned NUM_RGN = 1 << RGN_BITS;

  logic [RGN_BITS-1:0] base_q [NUM_RGN];
  logic [ATTR_W-1:0]   attr_q [NUM_RGN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_RGN; i++) begin
        base_q[i] <= RGN_BITS'(i);
        attr_q[i] <= RST_ATTR;
      end
    end else if (wr_en) begin
      base_q[wr_idx] <= wr_base;
      attr_q[wr_idx] <= wr_attr;
    end
  end

  assign rd_base = base_q[rd_idx];
  assign rd_attr = attr_q[rd_idx];

  // R10
  table_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (base_q[$past(wr_idx)] == $past(wr_base)) &&
              (attr_q[$past(wr_idx)] == $past(wr_attr)));
endmodule

// File: rtl/rgn_attr_decode.sv
module rgn_attr_decode
  import rgn_pkg::*;
(
  input  logic [ATTR_W-1:0] attr,
  input  logic              cattr_mode,
  output rights_t           rights
);
  always_comb begin
    rights = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, cm: CM_BYPASS};
    case (attr)
      4'd0:  rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, cm: CM_WTHRU};
      4'd1:  rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_WTHRU};
      4'd2:  rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_BYPASS};
      4'd3:  rights = '{rd: 1'b0, wr: 1'b0, ex: 1'b1, cm: CM_WBACK};
      4'd4:  rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_WBACK};
      4'd5:  if (!cattr_mode)
               rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_WBACK};
      4'd14: rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, cm: CM_ISOL};
      default: ;
    endcase
  end
endmodule

// File: rtl/rgn_resp_stage.sv
module rgn_resp_stage
  import rgn_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  rights_t           rights,
  input  logic [ADDR_W-1:0] paddr_in,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_cache,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause
);
  logic       granted;
  logic [1:0] deny_cause;

  always_comb begin
    case (req_kind)
      KIND_LOAD:  begin granted = rights.rd; deny_cause = CS_LOAD;  end
      KIND_STORE: begin granted = rights.wr; deny_cause = CS_STORE; end
      default:    begin granted = rights.ex; deny_cause = CS_FETCH; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_cache <= CM_BYPASS;
      rsp_fault <= 1'b0;
      rsp_cause <= CS_NONE;
    end else begin
      rsp_valid <= 1'b1;
      rsp_paddr <= granted ? paddr_in : '0;
      rsp_cache <= granted ? rights.cm : CM_BYPASS;
      rsp_fault <= !granted;
      rsp_cause <= granted ? CS_NONE : deny_cause;
    end
  end

  // R9
  rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && rsp_paddr == '0 && !rsp_fault);

  // R6
  store_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault && $past(req_kind) == KIND_STORE |-> rsp_cause == CS_STORE);

  // R6
  fault_blank_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_paddr == '0 && rsp_cache == CM_BYPASS && rsp_cause != CS_NONE);
endmodule

// File: rtl/rgn_guard_top.sv
module rgn_guard_top
  import rgn_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned RGN_BITS = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [RGN_BITS-1:0]          wr_idx,
  input  logic [RGN_BITS-1:0]          wr_base,
  input  logic [ATTR_W-1:0]            wr_attr,
  input  logic                         req_valid,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [1:0]                   req_kind,
  input  logic                         cattr_mode,
  input  logic [(1<<RGN_BITS)*ATTR_W-1:0] cattr_word,
  output logic                         rsp_valid,
  output logic [ADDR_W-1:0]            rsp_paddr,
  output logic [1:0]                   rsp_cache,
  output logic                         rsp_fault,
  output logic [1:0]                   rsp_cause
);
  localparam int unsigned OFF_W = ADDR_W - RGN_BITS;

  logic [RGN_BITS-1:0] seg_idx;
  logic [RGN_BITS-1:0] tbl_base;
  logic [ATTR_W-1:0]   tbl_attr;
  logic [ATTR_W-1:0]   word_attr;
  logic [ATTR_W-1:0]   sel_attr;
  logic [ADDR_W-1:0]   xlat_addr;
  rights_t             rights;

  assign seg_idx   = req_addr[ADDR_W-1 -: RGN_BITS];
  assign word_attr = cattr_word[seg_idx*ATTR_W +: ATTR_W];
  assign sel_attr  = cattr_mode ? word_attr : tbl_attr;
  assign xlat_addr = cattr_mode ? req_addr : {tbl_base, req_addr[OFF_W-1:0]};

  rgn_table #(.RGN_BITS(RGN_BITS), .ATTR_W(ATTR_W), .RST_ATTR(4'd2)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_base (wr_base),
    .wr_attr (wr_attr),
    .rd_idx  (seg_idx),
    .rd_base (tbl_base),
    .rd_attr (tbl_attr)
  );

  rgn_attr_decode u_decode (
    .attr       (sel_attr),
    .cattr_mode (cattr_mode),
    .rights     (rights)
  );

  rgn_resp_stage #(.ADDR_W(ADDR_W)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .rights    (rights),
    .paddr_in  (xlat_addr),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_cache (rsp_cache),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause)
  );

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]));

  // R8
  word_code5_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && cattr_mode && word_attr == 4'd5 |=> rsp_valid && rsp_fault);

  // R7
  word_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && cattr_mode |=> rsp_fault || rsp_paddr == $past(req_addr));
endmodule

// File: tb/tb_rgn_guard_top.sv
module tb_rgn_guard_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_idx, wr_base;
  logic [3:0]  wr_attr;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_kind;
  logic        cattr_mode;
  logic [31:0] cattr_word;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_cache, rsp_cause;

  rgn_guard_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
    .wr_attr(wr_attr), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .cattr_mode(cattr_mode), .cattr_word(cattr_word),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_cache(rsp_cache),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  int m_base [8];
  int m_attr [8];

  bit          e_valid, e_fault;
  logic [31:0] e_paddr;
  logic [1:0]  e_cache, e_cause;

  // Returns {rd,wr,ex,cache[1:0]} from the requirement tables (R4, R5, R8)
  function automatic logic [4:0] ref_rights(int code, bit wordmode);
    case (code)
      0:  return {3'b110, 2'd1};
      1:  return {3'b111, 2'd1};
      2:  return {3'b111, 2'd0};
      3:  return {3'b001, 2'd2};
      4:  return {3'b111, 2'd2};
      5:  return wordmode ? 5'b0 : {3'b111, 2'd2};
      14: return {3'b110, 2'd3};
      default: return 5'b0;
    endcase
  endfunction

  task automatic step(string tag, bit r, bit v, logic [31:0] a, logic [1:0] k,
                      bit cm, logic [31:0] cw, bit we, logic [2:0] wi,
                      logic [2:0] wb, logic [3:0] wa);
    logic [4:0] rt;
    bit ok;
    int idx, code;
    rst = r; req_valid = v; req_addr = a; req_kind = k; cattr_mode = cm;
    cattr_word = cw; wr_en = we; wr_idx = wi; wr_base = wb; wr_attr = wa;
    e_valid = 0; e_fault = 0; e_paddr = 0; e_cache = 0; e_cause = 0;
    if (r) begin
      for (int i = 0; i < 8; i++) begin m_base[i] = i; m_attr[i] = 2; end
    end else begin
      if (v) begin
        idx  = int'(a[31:29]);
        code = cm ? int'((cw >> (idx*4)) & 32'hf) : m_attr[idx];
        rt   = ref_rights(code, cm);
        case (k)
          2'd0: ok = rt[4];
          2'd1: ok = rt[3];
          default: ok = rt[2];
        endcase
        e_valid = 1;
        if (ok) begin
          e_paddr = cm ? a : {m_base[idx][2:0], a[28:0]};
          e_cache = rt[1:0];
        end else begin
          e_fault = 1;
          e_cause = (k == 2'd0) ? 2'd1 : (k == 2'd1) ? 2'd2 : 2'd3;
        end
      end
      if (we) begin m_base[wi] = int'(wb); m_attr[wi] = int'(wa); end
    end
    @(negedge clk);
    n_checks++;
    if (rsp_valid !== e_valid || rsp_fault !== e_fault || rsp_paddr !== e_paddr ||
        rsp_cache !== e_cache || rsp_cause !== e_cause) begin
      n_fails++;
      $display("FAIL %s: actual v=%0b f=%0b pa=%h c=%0d cause=%0d expected v=%0b f=%0b pa=%h c=%0d cause=%0d",
               tag, rsp_valid, rsp_fault, rsp_paddr, rsp_cache, rsp_cause,
               e_valid, e_fault, e_paddr, e_cache, e_cause);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fails++;
      $display("FAIL R9 watchdog: actual still running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rw;
    @(negedge clk);
    // Reset state: outputs idle
    for (int i = 0; i < 4; i++)
      step("R1 reset", 1, i > 1, 32'h1234_5678, 2'd0, 0, 0, 1, 3'd1, 3'd5, 4'd15);
    // R1: identity map, bypass, all kinds granted in every segment
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++)
        step("R1", 0, 1, {3'(s), 29'($urandom)}, 2'(k), 0, 0, 0, 0, 0, 0);
    // R9: idle cycles
    for (int i = 0; i < 3; i++)
      step("R9 idle", 0, 0, 32'hffff_ffff, 2'd1, 0, 0, 0, 0, 0, 0);
    // R10: same-cycle request sees old entry, next cycle sees new
    step("R10 old", 0, 1, 32'hA000_0040, 2'd2, 0, 0, 1, 3'd5, 3'd3, 4'd1);
    step("R10 new", 0, 1, 32'hA000_0040, 2'd2, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 1, 32'hBFFF_FFFC, 2'd0, 0, 0, 0, 0, 0, 0);
    // R4 / R5 / R11: sweep all codes on segment 2, all kinds
    for (int c = 0; c < 16; c++) begin
      step("R4 write", 0, 0, 0, 0, 0, 0, 1, 3'd2, 3'd6, 4'(c));
      for (int k = 0; k < 4; k++)
        step(k == 3 ? "R11" : (k == 1 ? "R6" : "R4/R5"), 0, 1,
             {3'd2, 29'($urandom)}, 2'(k), 0, 0, 0, 0, 0, 0);
    end
    // R2: upper bits select; neighbours unaffected by the segment 2 entry
    step("R2", 0, 1, 32'h3FFF_FFFF, 2'd1, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 1, 32'h6000_0000, 2'd1, 0, 0, 0, 0, 0, 0);
    // R7 / R8: word mode, each nibble code per segment
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 8; s++) begin
        rw = $urandom;
        rw[s*4 +: 4] = 4'(c);
        step(c == 5 ? "R8" : "R7", 0, 1, {3'(s), 29'($urandom)}, 2'($urandom), 1, rw, 0, 0, 0, 0);
      end
    // Mixed random traffic
    for (int i = 0; i < 3000; i++)
      step("R2/R3/R10 mix", 0, ($urandom % 4) != 0, $urandom, 2'($urandom),
           ($urandom % 3) == 0, $urandom, ($urandom % 3) == 0,
           3'($urandom), 3'($urandom), 4'($urandom % 7));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule